// File: doc/BRIEF.md
# Dual-Buffer Isochronous Receive Splitter

This block takes isochronous packets as a stream of 32-bit quadlets and divides each packet between two host memory areas named by a receive descriptor. The leading part of each packet goes into a header area in slots of fixed size. That part holds the bus header, the timestamp and the first payload quadlets. Every quadlet after that part is packed into a data area, with no gap between the tail of one packet and the start of the next. The stream carries start and end markers.

Software supplies descriptors through a valid/ready handshake. Each descriptor carries two base addresses, two request counts in bytes and the slot size. The block holds up to two descriptors: the active one and one waiting. It emits one memory write request per quadlet. When a descriptor is finished, it writes back the residual byte counts of both areas. If a packet's payload runs past the end of the active data area, the remaining quadlets continue in the waiting descriptor's data area. A descriptor with an illegal configuration is refused, and from then on the block stays halted.

Top module: `dual_buf_rx_split`

## Requirements
- R1: The first `first_size/4` quadlets of a packet are written with `wr_sel_o`=0 (header area) to consecutive quadlet addresses inside the packet's slot.
- R2: The quadlets that follow the slot are written with `wr_sel_o`=1 (data area) to `second_addr + bytes already used` of the active descriptor. Successive packets pack with no gap.
- R3: Each slot starts at `first_addr + k*first_size`, where k counts the earlier packets in that descriptor. A packet shorter than the slot still uses up the whole slot.
- R4: When a packet ends and its slot was the last one in the header area, `wb_valid_o` pulses together with that packet's last write. It reports a header residual of 0 and the data residual that remains.
- R5: A data write that fills the data area exactly raises `wb_valid_o` in the same cycle as that write. It reports a data residual of 0 and the header residual that remains.
- R6: Data quadlets that follow an exact fill inside the same packet go to the next descriptor's data area, starting at its base address. The next packet's slot starts at that descriptor's header base.
- R7: When a quadlet needs a descriptor and none is held, `miss_o` pulses in that quadlet's output cycle and no write is issued. The packet's remaining quadlets are dropped until the next start marker.
- R8: A descriptor is refused, and `cfg_err_o` goes high one cycle after the handshake and stays high, when any of these holds:
  - multichannel mode is on;
  - the slot size is 0 or not a multiple of 4;
  - the slot size is below 8 while the bus header is included;
  - the header request count is 0 or not a multiple of the slot size;
  - the header base is not quadlet-aligned;
  - the data request count is 0 or not a multiple of 4.
- R9: While `cfg_err_o` is high, packet quadlets produce no writes, write-backs or misses.
- R10: After reset, `wr_valid_o`, `wb_valid_o`, `miss_o` and `cfg_err_o` are low and `desc_ready_o` is high.
- R11: `desc_ready_o` is low exactly when two descriptors are held. A descriptor accepted on a clock edge can serve quadlets from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| multi_chan_i | input | 1 | Context is in multichannel mode (illegal here) |
| hdr_incl_i | input | 1 | Bus header is included in the slot |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_ready_o | output | 1 | Descriptor can be accepted |
| desc_first_addr_i | input | ADDR_W | Header area base address |
| desc_second_addr_i | input | ADDR_W | Data area base address |
| desc_first_req_i | input | CNT_W | Header area size in bytes |
| desc_second_req_i | input | CNT_W | Data area size in bytes |
| desc_first_size_i | input | CNT_W | Slot size in bytes |
| pkt_valid_i | input | 1 | Quadlet present |
| pkt_sop_i | input | 1 | First quadlet of packet |
| pkt_eop_i | input | 1 | Last quadlet of packet |
| pkt_data_i | input | 32 | Quadlet |
| wr_valid_o | output | 1 | Memory write request |
| wr_sel_o | output | 1 | 0 = header area, 1 = data area |
| wr_addr_o | output | ADDR_W | Write byte address |
| wr_data_o | output | 32 | Write data |
| wb_valid_o | output | 1 | Descriptor completed, residuals valid |
| wb_first_res_o | output | CNT_W | Header residual bytes |
| wb_second_res_o | output | CNT_W | Data residual bytes |
| miss_o | output | 1 | Quadlet needed a descriptor and none was held |
| cfg_err_o | output | 1 | Sticky configuration error |

## Verification
The hardest case to reach is a fill of the data area in the middle of a packet whose slot was already the last one. In that case the completion comes from the data side, the header residual is zero as well, and the rest of the packet moves to a descriptor that may or may not be loaded yet. The stimulus sweeps the slot size, the number of slots and the data area size over small values. It uses a packet-length sequence that shifts with each of these values, so exact fills, short slots and spills each fall at many different positions. Descriptors are topped up only between packets and from a limited supply, so the sweep also runs into the case where a spill finds no descriptor waiting.

// File: rtl/dbsplit_pkg.sv
`timescale 1ns/1ps
package dbsplit_pkg;
  localparam int unsigned QUAD_BYTES = 4;
  localparam int unsigned QUAD_W = 32;
  typedef enum logic {BUF_HDR = 1'b0, BUF_DATA = 1'b1} buf_sel_e;
endpackage

// File: rtl/dbsplit_cfg_check.sv
`timescale 1ns/1ps
module dbsplit_cfg_check #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              multi_chan_i,
  input  logic              hdr_incl_i,
  input  logic [ADDR_W-1:0] first_addr_i,
  input  logic [CNT_W-1:0]  first_req_i,
  input  logic [CNT_W-1:0]  second_req_i,
  input  logic [CNT_W-1:0]  first_size_i,
  output logic              bad_o
);
  localparam logic [CNT_W-1:0] MIN_HDR_SLOT = CNT_W'(8);

  logic [CNT_W-1:0] div;
  logic             size_bad, req_bad, align_bad, data_bad;

  always_comb begin
    div       = (first_size_i == '0) ? CNT_W'(1) : first_size_i;
    size_bad  = (first_size_i == '0) || (first_size_i[1:0] != 2'b00) ||
                (hdr_incl_i && (first_size_i < MIN_HDR_SLOT));
    req_bad   = (first_req_i == '0) || ((first_req_i % div) != '0);
    align_bad = (first_addr_i[1:0] != 2'b00);
    data_bad  = (second_req_i == '0) || (second_req_i[1:0] != 2'b00);
    bad_o     = multi_chan_i || size_bad || req_bad || align_bad || data_bad;
  end
endmodule

// File: rtl/dbsplit_desc_hold.sv
`timescale 1ns/1ps
module dbsplit_desc_hold #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              promote_i,
  input  logic [ADDR_W-1:0] in_faddr_i,
  input  logic [ADDR_W-1:0] in_saddr_i,
  input  logic [CNT_W-1:0]  in_freq_i,
  input  logic [CNT_W-1:0]  in_sreq_i,
  input  logic [CNT_W-1:0]  in_fsize_i,
  output logic              ready_o,
  output logic              cur_v_o,
  output logic [ADDR_W-1:0] cur_faddr_o,
  output logic [ADDR_W-1:0] cur_saddr_o,
  output logic [CNT_W-1:0]  cur_freq_o,
  output logic [CNT_W-1:0]  cur_sreq_o,
  output logic [CNT_W-1:0]  cur_fsize_o
);
  localparam int unsigned EW = 2*ADDR_W + 3*CNT_W;

  logic [EW-1:0] ent_q [2];
  logic [1:0]    v_q;
  logic [EW-1:0] in_ent;
  logic          slot0_busy;

  assign in_ent     = {in_faddr_i, in_saddr_i, in_freq_i, in_sreq_i, in_fsize_i};
  assign slot0_busy = promote_i ? v_q[1] : v_q[0];
  assign ready_o    = !v_q[1];
  assign cur_v_o    = v_q[0];
  assign {cur_faddr_o, cur_saddr_o, cur_freq_o, cur_sreq_o, cur_fsize_o} = ent_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q      <= '0;
      ent_q[0] <= '0;
      ent_q[1] <= '0;
    end else begin
      if (promote_i) begin
        ent_q[0] <= ent_q[1];
        v_q[0]   <= v_q[1];
        v_q[1]   <= 1'b0;
      end
      if (load_i) begin
        if (!slot0_busy) begin
          ent_q[0] <= in_ent;
          v_q[0]   <= 1'b1;
        end else begin
          ent_q[1] <= in_ent;
          v_q[1]   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dbsplit_router.sv
`timescale 1ns/1ps
module dbsplit_router
  import dbsplit_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic              pkt_valid_i,
  input  logic              pkt_sop_i,
  input  logic              pkt_eop_i,
  input  logic [QUAD_W-1:0] pkt_data_i,
  input  logic              cur_v_i,
  input  logic [ADDR_W-1:0] cur_faddr_i,
  input  logic [ADDR_W-1:0] cur_saddr_i,
  input  logic [CNT_W-1:0]  cur_freq_i,
  input  logic [CNT_W-1:0]  cur_sreq_i,
  input  logic [CNT_W-1:0]  cur_fsize_i,
  output logic              promote_o,
  output logic              wr_valid_o,
  output logic              wr_sel_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [QUAD_W-1:0] wr_data_o,
  output logic              wb_valid_o,
  output logic [CNT_W-1:0]  wb_fres_o,
  output logic [CNT_W-1:0]  wb_sres_o,
  output logic              miss_o
);
  localparam logic [CNT_W-1:0] QB = CNT_W'(QUAD_BYTES);

  // byte counts consumed in the active descriptor's two areas
  logic [CNT_W-1:0] f_used_q, f_used_n, s_used_q, s_used_n;
  logic [CNT_W-1:0] slot_q, slot_n, slot_c, fs_q, f_fin;
  logic             drop_q, drop_n, drop_c, spill_q, spill_n, spill_c, wrote;

  logic              wr_v_d, wb_d, miss_d;
  buf_sel_e          sel_d;
  logic [ADDR_W-1:0] addr_d;
  logic [CNT_W-1:0]  fres_d, sres_d;

  always_comb begin
    fs_q     = cur_fsize_i >> 2;
    f_used_n = f_used_q;
    s_used_n = s_used_q;
    slot_c   = slot_q;
    drop_c   = drop_q;
    spill_c  = spill_q;
    slot_n   = slot_q;
    drop_n   = drop_q;
    spill_n  = spill_q;
    f_fin    = '0;
    wrote    = 1'b0;
    wr_v_d   = 1'b0;
    sel_d    = BUF_HDR;
    addr_d   = '0;
    wb_d     = 1'b0;
    fres_d   = '0;
    sres_d   = '0;
    miss_d   = 1'b0;
    promote_o = 1'b0;
    if (pkt_valid_i && !halt_i) begin
      slot_c  = pkt_sop_i ? '0   : slot_q;
      drop_c  = pkt_sop_i ? 1'b0 : drop_q;
      spill_c = pkt_sop_i ? 1'b0 : spill_q;
      slot_n  = slot_c;
      drop_n  = drop_c;
      spill_n = spill_c;
      if (!drop_c) begin
        if (!cur_v_i) begin
          miss_d = 1'b1;
          drop_n = 1'b1;
        end else if (slot_c < fs_q) begin
          wr_v_d   = 1'b1;
          sel_d    = BUF_HDR;
          addr_d   = cur_faddr_i + ADDR_W'(f_used_q);
          f_used_n = f_used_q + QB;
          slot_n   = slot_c + 1'b1;
          wrote    = 1'b1;
        end else begin
          wr_v_d   = 1'b1;
          sel_d    = BUF_DATA;
          addr_d   = cur_saddr_i + ADDR_W'(s_used_q);
          s_used_n = s_used_q + QB;
          wrote    = 1'b1;
          if (s_used_n == cur_sreq_i) begin
            wb_d      = 1'b1;
            fres_d    = cur_freq_i - f_used_q;
            sres_d    = '0;
            promote_o = 1'b1;
            f_used_n  = '0;
            s_used_n  = '0;
            spill_n   = 1'b1;
          end
        end
        // a packet ending early still consumes its whole slot
        if (pkt_eop_i && wrote && !spill_n) begin
          f_fin    = f_used_n + cur_fsize_i - (slot_n << 2);
          f_used_n = f_fin;
          if (f_fin == cur_freq_i) begin
            wb_d      = 1'b1;
            fres_d    = '0;
            sres_d    = cur_sreq_i - s_used_n;
            promote_o = 1'b1;
            f_used_n  = '0;
            s_used_n  = '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_used_q   <= '0;
      s_used_q   <= '0;
      slot_q     <= '0;
      drop_q     <= 1'b0;
      spill_q    <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_sel_o   <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      wb_valid_o <= 1'b0;
      wb_fres_o  <= '0;
      wb_sres_o  <= '0;
      miss_o     <= 1'b0;
    end else begin
      f_used_q   <= f_used_n;
      s_used_q   <= s_used_n;
      slot_q     <= slot_n;
      drop_q     <= drop_n;
      spill_q    <= spill_n;
      wr_valid_o <= wr_v_d;
      wr_sel_o   <= sel_d;
      wr_addr_o  <= addr_d;
      wr_data_o  <= pkt_data_i;
      wb_valid_o <= wb_d;
      wb_fres_o  <= fres_d;
      wb_sres_o  <= sres_d;
      miss_o     <= miss_d;
    end
  end
endmodule

// File: rtl/dual_buf_rx_split.sv
`timescale 1ns/1ps
module dual_buf_rx_split
  import dbsplit_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              multi_chan_i,
  input  logic              hdr_incl_i,
  input  logic              desc_valid_i,
  output logic              desc_ready_o,
  input  logic [ADDR_W-1:0] desc_first_addr_i,
  input  logic [ADDR_W-1:0] desc_second_addr_i,
  input  logic [CNT_W-1:0]  desc_first_req_i,
  input  logic [CNT_W-1:0]  desc_second_req_i,
  input  logic [CNT_W-1:0]  desc_first_size_i,
  input  logic              pkt_valid_i,
  input  logic              pkt_sop_i,
  input  logic              pkt_eop_i,
  input  logic [31:0]       pkt_data_i,
  output logic              wr_valid_o,
  output logic              wr_sel_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [31:0]       wr_data_o,
  output logic              wb_valid_o,
  output logic [CNT_W-1:0]  wb_first_res_o,
  output logic [CNT_W-1:0]  wb_second_res_o,
  output logic              miss_o,
  output logic              cfg_err_o
);
  logic              desc_bad, desc_take, load, promote, cfg_err_q;
  logic              cur_v;
  logic [ADDR_W-1:0] cur_faddr, cur_saddr;
  logic [CNT_W-1:0]  cur_freq, cur_sreq, cur_fsize;

  assign desc_take = desc_valid_i && desc_ready_o && !cfg_err_q;
  assign load      = desc_take && !desc_bad;
  assign cfg_err_o = cfg_err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cfg_err_q <= 1'b0;
    else if (desc_take && desc_bad) cfg_err_q <= 1'b1;
  end

  dbsplit_cfg_check #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_check (
    .multi_chan_i (multi_chan_i),
    .hdr_incl_i   (hdr_incl_i),
    .first_addr_i (desc_first_addr_i),
    .first_req_i  (desc_first_req_i),
    .second_req_i (desc_second_req_i),
    .first_size_i (desc_first_size_i),
    .bad_o        (desc_bad)
  );

  dbsplit_desc_hold #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .promote_i   (promote),
    .in_faddr_i  (desc_first_addr_i),
    .in_saddr_i  (desc_second_addr_i),
    .in_freq_i   (desc_first_req_i),
    .in_sreq_i   (desc_second_req_i),
    .in_fsize_i  (desc_first_size_i),
    .ready_o     (desc_ready_o),
    .cur_v_o     (cur_v),
    .cur_faddr_o (cur_faddr),
    .cur_saddr_o (cur_saddr),
    .cur_freq_o  (cur_freq),
    .cur_sreq_o  (cur_sreq),
    .cur_fsize_o (cur_fsize)
  );

  dbsplit_router #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_router (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .halt_i      (cfg_err_q),
    .pkt_valid_i (pkt_valid_i),
    .pkt_sop_i   (pkt_sop_i),
    .pkt_eop_i   (pkt_eop_i),
    .pkt_data_i  (pkt_data_i),
    .cur_v_i     (cur_v),
    .cur_faddr_i (cur_faddr),
    .cur_saddr_i (cur_saddr),
    .cur_freq_i  (cur_freq),
    .cur_sreq_i  (cur_sreq),
    .cur_fsize_i (cur_fsize),
    .promote_o   (promote),
    .wr_valid_o  (wr_valid_o),
    .wr_sel_o    (wr_sel_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .wb_valid_o  (wb_valid_o),
    .wb_fres_o   (wb_first_res_o),
    .wb_sres_o   (wb_second_res_o),
    .miss_o      (miss_o)
  );
endmodule

// File: rtl/dual_buf_rx_split_chk.sv
`timescale 1ns/1ps
module dual_buf_rx_split_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_o,
  input logic              wr_sel_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              wb_valid_o,
  input logic [CNT_W-1:0]  wb_first_res_o,
  input logic [CNT_W-1:0]  wb_second_res_o,
  input logic              miss_o,
  input logic              cfg_err_o
);
  // completion needs one of the two areas exhausted (R4 / R5)
  assert_wb_one_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (wb_first_res_o == '0 || wb_second_res_o == '0));

  assert_cfg_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);

  assert_halt_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> !wr_valid_o && !wb_valid_o && !miss_o);

  assert_hdr_aligned_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_sel_o) |-> (wr_addr_o[1:0] == 2'b00));

  assert_miss_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> !wr_valid_o);
endmodule

bind dual_buf_rx_split dual_buf_rx_split_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_valid_o      (wr_valid_o),
  .wr_sel_o        (wr_sel_o),
  .wr_addr_o       (wr_addr_o),
  .wb_valid_o      (wb_valid_o),
  .wb_first_res_o  (wb_first_res_o),
  .wb_second_res_o (wb_second_res_o),
  .miss_o          (miss_o),
  .cfg_err_o       (cfg_err_o)
);

// File: tb/dual_buf_rx_split_test.sv
`timescale 1ns/1ps
module dual_buf_rx_split_test;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              multi_chan_i = 1'b0, hdr_incl_i = 1'b1;
  logic              desc_valid_i = 1'b0;
  logic              desc_ready_o;
  logic [ADDR_W-1:0] desc_first_addr_i = '0, desc_second_addr_i = '0;
  logic [CNT_W-1:0]  desc_first_req_i = '0, desc_second_req_i = '0, desc_first_size_i = '0;
  logic              pkt_valid_i = 1'b0, pkt_sop_i = 1'b0, pkt_eop_i = 1'b0;
  logic [31:0]       pkt_data_i = '0;
  logic              wr_valid_o, wr_sel_o, wb_valid_o, miss_o, cfg_err_o;
  logic [ADDR_W-1:0] wr_addr_o;
  logic [31:0]       wr_data_o;
  logic [CNT_W-1:0]  wb_first_res_o, wb_second_res_o;

  always #5 clk = ~clk;

  dual_buf_rx_split #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .multi_chan_i(multi_chan_i), .hdr_incl_i(hdr_incl_i),
    .desc_valid_i(desc_valid_i), .desc_ready_o(desc_ready_o),
    .desc_first_addr_i(desc_first_addr_i), .desc_second_addr_i(desc_second_addr_i),
    .desc_first_req_i(desc_first_req_i), .desc_second_req_i(desc_second_req_i),
    .desc_first_size_i(desc_first_size_i),
    .pkt_valid_i(pkt_valid_i), .pkt_sop_i(pkt_sop_i), .pkt_eop_i(pkt_eop_i), .pkt_data_i(pkt_data_i),
    .wr_valid_o(wr_valid_o), .wr_sel_o(wr_sel_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wb_valid_o(wb_valid_o), .wb_first_res_o(wb_first_res_o), .wb_second_res_o(wb_second_res_o),
    .miss_o(miss_o), .cfg_err_o(cfg_err_o)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  // reference state
  int m_fs, m_freq, m_sreq, m_L, m_C, m_fused, m_sused, m_slot;
  bit m_drop, m_spill, m_cfgerr;

  function automatic logic [31:0] fa(int i); return 32'h0001_0000 + 32'(i) * 32'h1000; endfunction
  function automatic logic [31:0] sa(int i); return 32'h0080_0000 + 32'(i) * 32'h2000; endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(int fs, int nslot, int sreq, bit hincl);
    rst_ni = 1'b0; desc_valid_i = 1'b0; pkt_valid_i = 1'b0; multi_chan_i = 1'b0;
    hdr_incl_i = hincl;
    m_fs = fs; m_freq = fs * nslot; m_sreq = sreq;
    m_L = 0; m_C = 0; m_fused = 0; m_sused = 0; m_slot = 0;
    m_drop = 0; m_spill = 0; m_cfgerr = 0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
  endtask

  task automatic load_desc(int i, logic [31:0] faddr, int freq, int sreq, int fs, bit bad);
    check("R11", "desc_ready", desc_ready_o, ((m_L - m_C) < 2) ? 1 : 0);
    desc_valid_i = 1'b1;
    desc_first_addr_i = faddr; desc_second_addr_i = sa(i);
    desc_first_req_i = CNT_W'(freq); desc_second_req_i = CNT_W'(sreq);
    desc_first_size_i = CNT_W'(fs);
    @(posedge clk); #1;
    desc_valid_i = 1'b0;
    if (bad) m_cfgerr = 1; else m_L++;
    check("R8", "cfg_err", cfg_err_o, m_cfgerr);
  endtask

  task automatic send_q(bit sop, bit eop, logic [31:0] d);
    bit e_wr = 0, e_sel = 0, e_wb = 0, e_miss = 0, spill_prev;
    logic [31:0] e_addr = '0;
    int e_fr = 0, e_sr = 0;
    string t_wr = "R2", t_wb = "R4";
    if (sop) begin m_slot = 0; m_drop = 0; m_spill = 0; end
    spill_prev = m_spill;
    if (m_cfgerr) t_wr = "R9";
    else if (m_drop) t_wr = "R7";
    else begin
      if (m_C >= m_L) begin e_miss = 1; m_drop = 1; t_wr = "R7"; end
      else if (m_slot < m_fs / 4) begin
        e_wr = 1; e_sel = 0; e_addr = fa(m_C) + 32'(m_fused);
        t_wr = (m_slot == 0) ? "R3" : "R1";
        m_fused += 4; m_slot++;
      end else begin
        e_wr = 1; e_sel = 1; e_addr = sa(m_C) + 32'(m_sused);
        t_wr = spill_prev ? "R6" : "R2";
        m_sused += 4;
        if (m_sused == m_sreq) begin
          e_wb = 1; t_wb = "R5"; e_fr = m_freq - m_fused; e_sr = 0;
          m_C++; m_fused = 0; m_sused = 0; m_spill = 1;
        end
      end
      if (eop && e_wr && !m_spill) begin
        m_fused += m_fs - 4 * m_slot;
        if (m_fused == m_freq) begin
          e_wb = 1; t_wb = "R4"; e_fr = 0; e_sr = m_sreq - m_sused;
          m_C++; m_fused = 0; m_sused = 0;
        end
      end
    end
    pkt_valid_i = 1'b1; pkt_sop_i = sop; pkt_eop_i = eop; pkt_data_i = d;
    @(posedge clk); #1;
    pkt_valid_i = 1'b0; pkt_sop_i = 1'b0; pkt_eop_i = 1'b0;
    check(t_wr, "wr_valid", wr_valid_o, e_wr);
    if (e_wr) begin
      check(t_wr, "wr_sel", wr_sel_o, e_sel);
      check(t_wr, "wr_addr", wr_addr_o, e_addr);
      check(t_wr, "wr_data", wr_data_o, d);
    end
    check(t_wb, "wb_valid", wb_valid_o, e_wb);
    if (e_wb) begin
      check(t_wb, "wb_first_res", wb_first_res_o, e_fr);
      check(t_wb, "wb_second_res", wb_second_res_o, e_sr);
    end
    check("R7", "miss", miss_o, e_miss);
  endtask

  task automatic send_pkt(int len, int pnum);
    for (int q = 0; q < len; q++)
      send_q(q == 0, q == len - 1, {8'hA5, pnum[7:0], q[15:0]});
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int fsl[3];
    int sql[3];
    fsl = '{8, 12, 16};
    sql = '{8, 20, 36};
    // R10 reset state
    do_reset(8, 1, 8, 1'b1);
    check("R10", "wr_valid", wr_valid_o, 0);
    check("R10", "wb_valid", wb_valid_o, 0);
    check("R10", "miss", miss_o, 0);
    check("R10", "cfg_err", cfg_err_o, 0);
    check("R10", "desc_ready", desc_ready_o, 1);

    // sweep slot size, slot count and data size
    for (int a = 0; a < 3; a++)
      for (int ns = 1; ns <= 3; ns++)
        for (int b = 0; b < 3; b++) begin
          int nd;
          nd = 0;
          do_reset(fsl[a], ns, sql[b], 1'b1);
          for (int k = 0; k < 2; k++) begin
            load_desc(nd, fa(nd), m_freq, m_sreq, m_fs, 1'b0); nd++;
          end
          for (int p = 0; p < 10; p++) begin
            if (nd < 5 && (m_L - m_C) < 2) begin
              load_desc(nd, fa(nd), m_freq, m_sreq, m_fs, 1'b0); nd++;
            end
            send_pkt(1 + ((p * 5 + m_fs / 4 + ns + b) % 9), p);
          end
        end

    // R6/R7: spill with no waiting descriptor
    do_reset(8, 3, 8, 1'b1);
    load_desc(0, fa(0), m_freq, m_sreq, m_fs, 1'b0);
    send_pkt(6, 1);
    send_pkt(3, 2);

    // R8 good slot of one quadlet when the bus header is excluded
    do_reset(4, 2, 8, 1'b0);
    load_desc(0, fa(0), 8, 8, 4, 1'b0);
    send_pkt(2, 3);
    send_pkt(3, 4);

    // R8/R9 each illegal configuration
    for (int v = 0; v < 7; v++) begin
      do_reset(8, 2, 8, 1'b1);
      multi_chan_i = (v == 6);
      case (v)
        0: load_desc(0, fa(0), 12, 8, 6, 1'b1);
        1: load_desc(0, fa(0), 8, 8, 4, 1'b1);
        2: load_desc(0, fa(0), 20, 8, 8, 1'b1);
        3: load_desc(0, fa(0) + 32'h2, 16, 8, 8, 1'b1);
        4: load_desc(0, fa(0), 16, 0, 8, 1'b1);
        5: load_desc(0, fa(0), 16, 10, 8, 1'b1);
        default: load_desc(0, fa(0), 16, 8, 8, 1'b1);
      endcase
      multi_chan_i = 1'b0;
      load_desc(1, fa(1), 16, 8, 8, 1'b1);
      send_pkt(4, 5);
      check("R8", "cfg_err held", cfg_err_o, 1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule